// File: doc/BRIEF.md
# Multi-cycle instruction sequencer

This block is the control unit and datapath core of a small 16-bit processor with word addressing. It holds the program counter and the instruction register, and it walks each instruction through fetch, decode, execute, memory and writeback states. Only the states an instruction needs are visited, so instructions take three, four or five clocks. The block drives an external 256-word by 16-bit memory through a combinational-read, clocked-write port. The 16-entry register file and an arithmetic unit with four flag bits are inside the block.

Instruction words are split as opcode [15:12] and a first register field [11:8]. Register-register forms add a second source [7:4] and a destination or mode field [3:0]. Immediate forms carry an 8-bit value in [7:0], and jumps take their target from the low 8 bits of [11:0]. Two addresses at the top of the space are reserved for I/O. 0xFE returns an 8-bit input port, zero-extended. A store to 0xFF updates an output register. Neither of these addresses touches the memory.

Top module: `mcyc_core`

## Requirements
- R1: While reset is held and in the first fetch after it, the PC is 0, the memory address is 0, the output port is 0, memory write is low and every register reads 0.
- R2: Opcodes 0000 add, 0001 subtract, 0010 AND, 0011 OR and 0100 XOR combine register [11:8] with register [7:4] and write the result to register [3:0]. Each takes four clocks.
- R3: Add and subtract set carry (carry out of the 17-bit sum, with subtract computed as a + ~b + 1) and signed overflow. AND, OR and XOR leave all four flags unchanged.
- R4: Opcode 0110 compares register [11:8] with register [7:4] as unsigned values. It writes the compare flags as 10 for less, 01 for equal and 00 for greater, and it writes no register.
- R5: Opcode 1000 with immediate 0 loads the word that follows the instruction into register [11:8] and resumes after that word. It takes five clocks.
- R6: Opcode 1000 with a nonzero immediate loads the word at (instruction address + 1 + immediate) mod 256 into register [11:8]. It does not skip a word.
- R7: Opcode 1011 loads, and opcode 1100 stores, register [11:8] at address (register 1 + immediate) mod 256. The load takes five clocks and the store takes four.
- R8: Opcode 1010 branches to instruction address + 1 + immediate when the condition in [11:8] holds. The conditions are 1000 less, 0100 equal, 1100 less-or-equal, 0000 greater, 0010 overflow, 0001 carry, and 0011 overflow and carry. A branch takes three clocks.
- R9: Opcode 1101 jumps to [7:0]. Opcode 1110 also writes instruction address + 1 into register 15.
- R10: Opcode 0111 jumps to the low 8 bits of register [11:8].
- R11: A load from 0xFE returns the input port zero-extended to 16 bits. A store to 0xFF updates the output port. Memory write is never asserted at 0xFE or 0xFF.
- R12: Opcode 0101 shifts register [11:8] by the low 4 bits of register [7:4] and writes the result back to register [11:8]. Mode bit [3] set means right, and for a right shift bit [0] set means arithmetic. Carry takes the last bit shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| mem_addr_o | output | 8 | Memory word address |
| mem_wdata_o | output | 16 | Store data |
| mem_we_o | output | 1 | Memory write strobe, taken at the clock edge |
| mem_rdata_i | input | 16 | Read data for mem_addr_o, same cycle |
| io_in_i | input | 8 | Input port read at 0xFE |
| io_out_o | output | 16 | Output register written at 0xFF |

## Verification
The bench goes after the load-immediate skip and the store timing together. It counts clocks from reset release to the first update of the output port. A sequencer that did not skip the data word would execute it, and one with an extra or missing state would move that update off clock eleven. Branches are checked with marker stores placed right after them, in both the taken and the not-taken direction. This catches a wrong condition decode, flags that logic operations clobbered, and a displacement measured from the wrong base. The I/O addresses are reached through index-register arithmetic. A decoder that let a store through to memory would corrupt the preset words at 0xFE and 0xFF, and a bench monitor flags any write strobe seen there.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0, OP_SUB  = 4'h1, OP_AND  = 4'h2, OP_OR   = 4'h3,
    OP_XOR  = 4'h4, OP_SHFT = 4'h5, OP_SET  = 4'h6, OP_JR   = 4'h7,
    OP_LWI  = 4'h8, OP_RSV9 = 4'h9, OP_BR   = 4'hA, OP_LWX  = 4'hB,
    OP_SWX  = 4'hC, OP_J    = 4'hD, OP_JAL  = 4'hE, OP_RSVF = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_MEM    = 3'd3,
    ST_WB     = 3'd4
  } state_e;

  typedef struct packed {
    logic [1:0] cmp;
    logic       ovf;
    logic       cry;
  } flags_t;

  function automatic logic is_alu(input opcode_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) || (op == OP_OR) ||
           (op == OP_XOR) || (op == OP_SHFT) || (op == OP_SET);
  endfunction

  function automatic logic is_memop(input opcode_e op);
    return (op == OP_LWI) || (op == OP_LWX) || (op == OP_SWX);
  endfunction

  // branch condition evaluation against the flag register
  function automatic logic cond_met(input logic [3:0] code, input flags_t f);
    logic hit;
    case (code)
      4'b1000: hit = (f.cmp == 2'b10);
      4'b0100: hit = (f.cmp == 2'b01);
      4'b1100: hit = (f.cmp == 2'b10) || (f.cmp == 2'b01);
      4'b0000: hit = (f.cmp == 2'b00);
      4'b0010: hit = f.ovf;
      4'b0001: hit = f.cry;
      4'b0011: hit = f.ovf && f.cry;
      default: hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  opcode_e op_i,
  output state_e  state_o
);

  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: state_d = ST_EXEC;
      ST_EXEC: begin
        if (is_alu(op_i))        state_d = ST_WB;
        else if (is_memop(op_i)) state_d = ST_MEM;
        else                     state_d = ST_FETCH;
      end
      ST_MEM:  state_d = (op_i == OP_SWX) ? ST_FETCH : ST_WB;
      ST_WB:   state_d = ST_FETCH;
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R2: every instruction is decoded in the cycle after its fetch
  p_decode_after_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH) |=> (state_q == ST_DECODE));

  // R7: a store finishes in its memory cycle
  p_store_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MEM && op_i == OP_SWX) |=> (state_q == ST_FETCH));

  // R8: branches finish in the execute cycle
  p_branch_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXEC && op_i == OP_BR) |=> (state_q == ST_FETCH));

endmodule

// File: rtl/mcyc_regfile.sv
module mcyc_regfile #(
  parameter int DATA_W  = 16,
  parameter int REG_CNT = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we_i,
  input  logic [$clog2(REG_CNT)-1:0] waddr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [$clog2(REG_CNT)-1:0] raddr_a_i,
  output logic [DATA_W-1:0]          rdata_a_o,
  input  logic [$clog2(REG_CNT)-1:0] raddr_b_i,
  output logic [DATA_W-1:0]          rdata_b_o
);

  localparam int AW = $clog2(REG_CNT);

  logic [DATA_W-1:0] regs [REG_CNT];

  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic              en;
    assign en = we_i && (waddr_i == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata_i;
    end
    assign regs[g] = q;
  end

  assign rdata_a_o = regs[raddr_a_i];
  assign rdata_b_o = regs[raddr_b_i];

endmodule

// File: rtl/mcyc_alu.sv
module mcyc_alu
  import mcyc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  opcode_e           op_i,
  input  logic [3:0]        mode_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o,
  output logic              ovf_o,
  output logic              cry_o,
  output logic              vc_upd_o,
  output logic [1:0]        cmp_o,
  output logic              cmp_upd_o
);

  localparam int SH_W = $clog2(DATA_W);
  localparam int MSB  = DATA_W - 1;

  logic [DATA_W:0]        add_x, sub_x, shl_x, shr_x;
  logic signed [DATA_W:0] shr_src;
  logic [SH_W-1:0]        amt;

  assign amt     = b_i[SH_W-1:0];
  assign add_x   = {1'b0, a_i} + {1'b0, b_i};
  assign sub_x   = {1'b0, a_i} + {1'b0, ~b_i} + {{DATA_W{1'b0}}, 1'b1};
  assign shl_x   = {1'b0, a_i} << amt;
  assign shr_src = {a_i, 1'b0};
  assign shr_x   = mode_i[0] ? $unsigned(shr_src >>> amt) : ({a_i, 1'b0} >> amt);

  always_comb begin
    y_o       = '0;
    ovf_o     = 1'b0;
    cry_o     = 1'b0;
    vc_upd_o  = 1'b0;
    cmp_o     = 2'b00;
    cmp_upd_o = 1'b0;
    case (op_i)
      OP_ADD: begin
        y_o      = add_x[DATA_W-1:0];
        cry_o    = add_x[DATA_W];
        ovf_o    = (a_i[MSB] == b_i[MSB]) && (add_x[MSB] != a_i[MSB]);
        vc_upd_o = 1'b1;
      end
      OP_SUB: begin
        y_o      = sub_x[DATA_W-1:0];
        cry_o    = sub_x[DATA_W];
        ovf_o    = (a_i[MSB] != b_i[MSB]) && (sub_x[MSB] != a_i[MSB]);
        vc_upd_o = 1'b1;
      end
      OP_AND: y_o = a_i & b_i;
      OP_OR:  y_o = a_i | b_i;
      OP_XOR: y_o = a_i ^ b_i;
      OP_SHFT: begin
        if (mode_i[3]) begin
          y_o   = shr_x[DATA_W:1];
          cry_o = shr_x[0];
        end else begin
          y_o   = shl_x[DATA_W-1:0];
          cry_o = shl_x[DATA_W];
        end
        vc_upd_o = 1'b1;
      end
      OP_SET: begin
        cmp_o     = (a_i < b_i) ? 2'b10 : ((a_i == b_i) ? 2'b01 : 2'b00);
        cmp_upd_o = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mcyc_core.sv
module mcyc_core
  import mcyc_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 8,
  parameter int REG_CNT = 16,
  parameter int IN_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [IN_W-1:0]   io_in_i,
  output logic [DATA_W-1:0] io_out_o
);

  localparam int                RAW         = $clog2(REG_CNT);
  localparam logic [ADDR_W-1:0] IO_IN_ADDR  = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] IO_OUT_ADDR = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] PC_STEP     = ADDR_W'(1);
  localparam logic [RAW-1:0]    IDX_REG     = RAW'(1);
  localparam logic [RAW-1:0]    LINK_REG    = RAW'(REG_CNT - 1);

  // reset: asynchronous assert, synchronous release
  logic rst_s1_q, rst_s2_q, core_rst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign core_rst_n = rst_s2_q;

  // architectural and pipeline-free holding registers
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [DATA_W-1:0] ir_q, opa_q, opb_q, res_q, res_d, mdr_q, mdr_d, out_q;
  flags_t            flags_q, flg_d;
  logic pc_en, ir_en, opab_en, res_en, mdr_en, flg_en, out_en;

  // instruction fields
  opcode_e           op;
  logic [RAW-1:0]    f_rs, f_rt, f_rd;
  logic [7:0]        imm8;
  logic [ADDR_W-1:0] imm_a, lwi_addr, idx_addr, mem_addr;
  logic              mem_we;

  assign op    = opcode_e'(ir_q[15:12]);
  assign f_rs  = RAW'(ir_q[11:8]);
  assign f_rt  = RAW'(ir_q[7:4]);
  assign f_rd  = RAW'(ir_q[3:0]);
  assign imm8  = ir_q[7:0];
  assign imm_a = ADDR_W'(imm8);

  state_e state;
  mcyc_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .op_i    (op),
    .state_o (state)
  );

  // register file
  logic              rf_we;
  logic [RAW-1:0]    rf_waddr, rf_rb_addr;
  logic [DATA_W-1:0] rf_wdata, rf_rda, rf_rdb;

  assign rf_rb_addr = (op == OP_LWX || op == OP_SWX) ? IDX_REG : f_rt;

  mcyc_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_rf (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .we_i      (rf_we),
    .waddr_i   (rf_waddr),
    .wdata_i   (rf_wdata),
    .raddr_a_i (f_rs),
    .rdata_a_o (rf_rda),
    .raddr_b_i (rf_rb_addr),
    .rdata_b_o (rf_rdb)
  );

  // arithmetic unit
  logic [DATA_W-1:0] alu_y;
  logic              alu_ovf, alu_cry, alu_vc_upd, alu_cmp_upd;
  logic [1:0]        alu_cmp;

  mcyc_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i      (op),
    .mode_i    (ir_q[3:0]),
    .a_i       (opa_q),
    .b_i       (opb_q),
    .y_o       (alu_y),
    .ovf_o     (alu_ovf),
    .cry_o     (alu_cry),
    .vc_upd_o  (alu_vc_upd),
    .cmp_o     (alu_cmp),
    .cmp_upd_o (alu_cmp_upd)
  );

  assign lwi_addr = (imm8 == 8'd0) ? pc_q : (pc_q + imm_a);
  assign idx_addr = opb_q[ADDR_W-1:0] + imm_a;

  // next-state logic for the datapath
  always_comb begin
    pc_en    = 1'b0;
    pc_d     = pc_q;
    ir_en    = 1'b0;
    opab_en  = 1'b0;
    res_en   = 1'b0;
    res_d    = res_q;
    mdr_en   = 1'b0;
    mdr_d    = mdr_q;
    flg_en   = 1'b0;
    flg_d    = flags_q;
    out_en   = 1'b0;
    rf_we    = 1'b0;
    rf_waddr = f_rs;
    rf_wdata = res_q;
    mem_addr = pc_q;
    mem_we   = 1'b0;
    case (state)
      ST_FETCH: begin
        ir_en = 1'b1;
        pc_en = 1'b1;
        pc_d  = pc_q + PC_STEP;
      end
      ST_DECODE: opab_en = 1'b1;
      ST_EXEC: begin
        case (op)
          OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_SHFT, OP_SET: begin
            res_en = 1'b1;
            res_d  = alu_y;
            flg_en = alu_vc_upd || alu_cmp_upd;
            if (alu_vc_upd) begin
              flg_d.ovf = alu_ovf;
              flg_d.cry = alu_cry;
            end
            if (alu_cmp_upd) flg_d.cmp = alu_cmp;
          end
          OP_JR: begin
            pc_en = 1'b1;
            pc_d  = opa_q[ADDR_W-1:0];
          end
          OP_LWI: begin
            res_en = 1'b1;
            res_d  = DATA_W'(lwi_addr);
            if (imm8 == 8'd0) begin
              pc_en = 1'b1;
              pc_d  = pc_q + PC_STEP;
            end
          end
          OP_LWX, OP_SWX: begin
            res_en = 1'b1;
            res_d  = DATA_W'(idx_addr);
          end
          OP_BR: begin
            if (cond_met(ir_q[11:8], flags_q)) begin
              pc_en = 1'b1;
              pc_d  = pc_q + imm_a;
            end
          end
          OP_J: begin
            pc_en = 1'b1;
            pc_d  = ir_q[ADDR_W-1:0];
          end
          OP_JAL: begin
            pc_en    = 1'b1;
            pc_d     = ir_q[ADDR_W-1:0];
            rf_we    = 1'b1;
            rf_waddr = LINK_REG;
            rf_wdata = DATA_W'(pc_q);
          end
          default: ;
        endcase
      end
      ST_MEM: begin
        mem_addr = res_q[ADDR_W-1:0];
        if (op == OP_SWX) begin
          if (mem_addr == IO_OUT_ADDR)     out_en = 1'b1;
          else if (mem_addr != IO_IN_ADDR) mem_we = 1'b1;
        end else begin
          mdr_en = 1'b1;
          if (mem_addr == IO_IN_ADDR)       mdr_d = DATA_W'(io_in_i);
          else if (mem_addr == IO_OUT_ADDR) mdr_d = out_q;
          else                              mdr_d = mem_rdata_i;
        end
      end
      ST_WB: begin
        if (is_alu(op) && op != OP_SET) begin
          rf_we    = 1'b1;
          rf_waddr = (op == OP_SHFT) ? f_rs : f_rd;
          rf_wdata = res_q;
        end else if (op == OP_LWI || op == OP_LWX) begin
          rf_we    = 1'b1;
          rf_waddr = f_rs;
          rf_wdata = mdr_q;
        end
      end
      default: ;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pc_q    <= '0;
      ir_q    <= '0;
      opa_q   <= '0;
      opb_q   <= '0;
      res_q   <= '0;
      mdr_q   <= '0;
      flags_q <= '0;
      out_q   <= '0;
    end else begin
      if (pc_en)   pc_q    <= pc_d;
      if (ir_en)   ir_q    <= mem_rdata_i;
      if (opab_en) begin
        opa_q <= rf_rda;
        opb_q <= rf_rdb;
      end
      if (res_en)  res_q   <= res_d;
      if (mdr_en)  mdr_q   <= mdr_d;
      if (flg_en)  flags_q <= flg_d;
      if (out_en)  out_q   <= opa_q;
    end
  end

  assign mem_addr_o  = mem_addr;
  assign mem_we_o    = mem_we;
  assign mem_wdata_o = opa_q;
  assign io_out_o    = out_q;

  // R11: the reserved I/O words never see a memory write
  p_io_no_ram_write_r11: assert property (@(posedge clk) disable iff (!core_rst_n)
    mem_we_o |-> (mem_addr_o != IO_IN_ADDR && mem_addr_o != IO_OUT_ADDR));

  // R11: the output port moves only after a store cycle
  p_out_only_store_r11: assert property (@(posedge clk) disable iff (!core_rst_n)
    !$stable(io_out_o) |-> $past(state == ST_MEM && op == OP_SWX));

  // R5: each fetch advances the PC by one word
  p_fetch_step_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (state == ST_FETCH) |=> (pc_q == $past(pc_q) + PC_STEP));

  // R5: the next-word load form skips its data word
  p_lwi_skip_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (state == ST_EXEC && op == OP_LWI && imm8 == 8'd0) |=> (pc_q == $past(pc_q) + PC_STEP));

  // R9: registers are written only in writeback or by the linking jump
  p_rf_write_phase_r9: assert property (@(posedge clk) disable iff (!core_rst_n)
    rf_we |-> (state == ST_WB || (state == ST_EXEC && op == OP_JAL)));

endmodule

// File: tb/mcyc_core_tb.sv
`timescale 1ns/1ps
module mcyc_core_tb;

  localparam logic [3:0] O_ADD = 4'h0, O_SUB = 4'h1, O_AND = 4'h2, O_OR = 4'h3,
                         O_XOR = 4'h4, O_SHF = 4'h5, O_SET = 4'h6, O_JR = 4'h7,
                         O_LWI = 4'h8, O_BR = 4'hA, O_LWX = 4'hB, O_SWX = 4'hC,
                         O_J = 4'hD, O_JAL = 4'hE;
  localparam logic [3:0] C_LT = 4'b1000, C_EQ = 4'b0100, C_LE = 4'b1100, C_GT = 4'b0000,
                         C_V = 4'b0010, C_C = 4'b0001, C_VC = 4'b0011;
  localparam logic [15:0] MARK = 16'hDEAD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata, mem_rdata, io_out;
  logic        mem_we;
  logic [7:0]  io_in = 8'h00;
  logic [15:0] ram [256];

  int  checks = 0;
  int  fails = 0;
  int  io_bad = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  assign mem_rdata = ram[mem_addr];
  always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;
  always @(negedge clk) if (rst_n && mem_we && mem_addr >= 8'hFE) io_bad++;

  mcyc_core u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_we_o    (mem_we),
    .mem_rdata_i (mem_rdata),
    .io_in_i     (io_in),
    .io_out_o    (io_out)
  );

  function automatic logic [15:0] enc_r(input logic [3:0] op, rs, rt, rd);
    return {op, rs, rt, rd};
  endfunction
  function automatic logic [15:0] enc_i(input logic [3:0] op, rs, input logic [7:0] imm);
    return {op, rs, imm};
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    for (int i = 0; i < 256; i++) ram[i] <= 16'h0000;
    @(posedge clk);
  endtask

  task automatic put(input int a, input logic [15:0] v);
    ram[a] <= v;
  endtask

  task automatic release_run(input int n);
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    hold_reset();
    @(negedge clk);
    chk("R1", "out in reset", io_out, 16'h0000);
    chk("R1", "we in reset", {15'd0, mem_we}, 16'h0000);
    chk("R1", "addr in reset", {8'd0, mem_addr}, 16'h0000);
  endtask

  // load-immediate then store to output: update lands on edge 11 after release
  task automatic t_timing();
    hold_reset();
    put(0, enc_i(O_LWI, 4'd2, 8'h00));
    put(1, 16'h1234);
    put(2, enc_i(O_SWX, 4'd2, 8'hFF));
    put(3, enc_i(O_J, 4'd0, 8'h03));
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "first fetch addr", {8'd0, mem_addr}, 16'h0000);
    repeat (9) @(posedge clk);
    @(negedge clk);
    chk("R5", "out before edge 11 (R7 store length)", io_out, 16'h0000);
    @(posedge clk);
    @(negedge clk);
    chk("R7", "out at edge 11 (R5 load length)", io_out, 16'h1234);
  endtask

  task automatic t_alu();
    hold_reset();
    put(0, enc_i(O_LWI, 4'd2, 8'h00)); put(1, 16'h8000);
    put(2, enc_i(O_LWI, 4'd3, 8'h00)); put(3, 16'h8001);
    put(4, enc_r(O_ADD, 4'd2, 4'd3, 4'd4));
    put(5, enc_i(O_BR, C_VC, 8'd1));
    put(6, enc_i(O_SWX, 4'd2, 8'h90));
    put(7, enc_r(O_AND, 4'd2, 4'd3, 4'd5));
    put(8, enc_i(O_BR, C_C, 8'd1));
    put(9, enc_i(O_SWX, 4'd2, 8'h91));
    put(10, enc_r(O_OR, 4'd2, 4'd3, 4'd6));
    put(11, enc_r(O_XOR, 4'd2, 4'd3, 4'd7));
    put(12, enc_r(O_SUB, 4'd3, 4'd2, 4'd8));
    put(13, enc_i(O_BR, C_V, 8'd1));
    put(14, enc_i(O_SWX, 4'd3, 8'h92));
    put(15, enc_i(O_SWX, 4'd4, 8'h80));
    put(16, enc_i(O_SWX, 4'd5, 8'h81));
    put(17, enc_i(O_SWX, 4'd6, 8'h82));
    put(18, enc_i(O_SWX, 4'd7, 8'h83));
    put(19, enc_i(O_SWX, 4'd8, 8'h84));
    put(20, enc_i(O_J, 4'd0, 8'd20));
    put(8'h90, MARK); put(8'h91, MARK); put(8'h92, MARK);
    release_run(200);
    chk("R2", "add", ram[8'h80], 16'h0001);
    chk("R2", "and", ram[8'h81], 16'h8000);
    chk("R2", "or", ram[8'h82], 16'h8001);
    chk("R2", "xor", ram[8'h83], 16'h0001);
    chk("R2", "sub", ram[8'h84], 16'h0001);
    chk("R3", "add sets v and c, branch vc taken", ram[8'h90], MARK);
    chk("R3", "and keeps carry", ram[8'h91], MARK);
    chk("R8", "sub clears v, branch not taken", ram[8'h92], 16'h8001);
  endtask

  task automatic t_set();
    hold_reset();
    put(0, enc_i(O_LWI, 4'd2, 8'h00)); put(1, 16'h0005);
    put(2, enc_i(O_LWI, 4'd3, 8'h00)); put(3, 16'h0009);
    put(4, enc_r(O_SET, 4'd2, 4'd3, 4'd7));
    put(5, enc_i(O_BR, C_LT, 8'd1)); put(6, enc_i(O_SWX, 4'd2, 8'hA0));
    put(7, enc_i(O_BR, C_GT, 8'd1)); put(8, enc_i(O_SWX, 4'd2, 8'hA1));
    put(9, enc_i(O_BR, C_LE, 8'd1)); put(10, enc_i(O_SWX, 4'd2, 8'hA2));
    put(11, enc_r(O_SET, 4'd3, 4'd2, 4'd0));
    put(12, enc_i(O_BR, C_GT, 8'd1)); put(13, enc_i(O_SWX, 4'd2, 8'hA3));
    put(14, enc_r(O_SET, 4'd2, 4'd2, 4'd0));
    put(15, enc_i(O_BR, C_EQ, 8'd1)); put(16, enc_i(O_SWX, 4'd2, 8'hA4));
    put(17, enc_i(O_BR, C_LE, 8'd1)); put(18, enc_i(O_SWX, 4'd2, 8'hA5));
    put(19, enc_i(O_SWX, 4'd7, 8'hA6));
    put(20, enc_i(O_J, 4'd0, 8'd20));
    for (int i = 8'hA0; i <= 8'hA6; i++) put(i, MARK);
    release_run(200);
    chk("R8", "lt taken", ram[8'hA0], MARK);
    chk("R4", "less is not greater", ram[8'hA1], 16'h0005);
    chk("R8", "le taken on less", ram[8'hA2], MARK);
    chk("R4", "greater code", ram[8'hA3], MARK);
    chk("R4", "equal code", ram[8'hA4], MARK);
    chk("R8", "le taken on equal", ram[8'hA5], MARK);
    chk("R4", "compare writes no register", ram[8'hA6], 16'h0000);
  endtask

  task automatic t_mem();
    hold_reset();
    io_in = 8'hC3;
    put(0, enc_i(O_LWI, 4'd1, 8'h00)); put(1, 16'h0040);
    put(2, enc_i(O_LWI, 4'd2, 8'h10));
    put(3, enc_i(O_LWX, 4'd3, 8'h02));
    put(4, enc_i(O_SWX, 4'd3, 8'h05));
    put(5, {O_JAL, 4'h0, 8'h20});
    put(6, enc_i(O_LWX, 4'd4, 8'hBE));
    put(7, enc_i(O_SWX, 4'd4, 8'hBF));
    put(8, enc_i(O_SWX, 4'd2, 8'h06));
    put(9, enc_i(O_SWX, 4'd15, 8'h07));
    put(10, enc_i(O_J, 4'd0, 8'd10));
    put(8'h13, 16'h5A5A);
    put(8'h20, enc_i(O_SWX, 4'd3, 8'hBE));
    put(8'h21, enc_r(O_JR, 4'd15, 4'd0, 4'd0));
    put(8'h42, 16'h1357);
    put(8'hFE, MARK); put(8'hFF, MARK);
    release_run(200);
    chk("R6", "pc-relative load", ram[8'h46], 16'h5A5A);
    chk("R7", "indexed load and store", ram[8'h45], 16'h1357);
    chk("R9", "link register", ram[8'h47], 16'h0006);
    chk("R10", "return through jr reached the input read", io_out, 16'h00C3);
    chk("R11", "ram at FF untouched", ram[8'hFF], MARK);
    chk("R11", "ram at FE untouched", ram[8'hFE], MARK);
    chk("R6", "source word intact", ram[8'h13], 16'h5A5A);
  endtask

  task automatic t_shift();
    hold_reset();
    put(0, enc_i(O_LWI, 4'd2, 8'h00)); put(1, 16'h8001);
    put(2, enc_i(O_LWI, 4'd3, 8'h00)); put(3, 16'h0001);
    put(4, enc_r(O_SHF, 4'd2, 4'd3, 4'b0000));
    put(5, enc_i(O_BR, C_C, 8'd1)); put(6, enc_i(O_SWX, 4'd3, 8'hB0));
    put(7, enc_i(O_SWX, 4'd2, 8'hB1));
    put(8, enc_i(O_LWI, 4'd4, 8'h00)); put(9, 16'h8000);
    put(10, enc_i(O_LWI, 4'd5, 8'h00)); put(11, 16'h0004);
    put(12, enc_r(O_SHF, 4'd4, 4'd5, 4'b1001));
    put(13, enc_i(O_SWX, 4'd4, 8'hB2));
    put(14, enc_i(O_LWI, 4'd6, 8'h00)); put(15, 16'h8000);
    put(16, enc_r(O_SHF, 4'd6, 4'd5, 4'b1000));
    put(17, enc_i(O_SWX, 4'd6, 8'hB3));
    put(18, enc_i(O_J, 4'd0, 8'd18));
    put(8'hB0, MARK);
    release_run(200);
    chk("R12", "left shift carry out", ram[8'hB0], MARK);
    chk("R12", "left shift", ram[8'hB1], 16'h0002);
    chk("R12", "arithmetic right", ram[8'hB2], 16'hF800);
    chk("R12", "logical right", ram[8'hB3], 16'h0800);
  endtask

  initial begin
    t_reset();
    t_timing();
    t_alu();
    t_set();
    t_mem();
    t_shift();
    chk("R11", "no write strobe at FE or FF", 16'(io_bad), 16'h0000);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule